// File: doc/BRIEF.md
# Receive descriptor ring status writer

This block is the write-back side of a receive DMA ring. Each time a frame has been placed into a buffer, the block writes a packed status word into an on-chip descriptor array. It then advances a free-running 16-bit producer index. Software gives slots back by loading a 16-bit consumer index. When the ring holds as many written, unconsumed descriptors as it has slots, further frames are refused and counted.

Each descriptor takes three 32-bit words: the status word, then the low and high halves of the buffer address. Software loads the address words through a separate write port. The block only stores them. A done pulse tells software that work is waiting. The pulse is coalesced: it fires when a count threshold of unreported descriptors is reached, or when a coarse idle timer expires while something is still unreported.

Configuration comes from single-word writes. They set the ring start and end (in descriptor-word units), the ring size and buffer size (one word), the done threshold, the timeout and the consumer index.

Top module: `rxring_wb`

## Requirements
- R1: After a synchronous active-high reset, the block is in this state:
  - producer index 0, drop count 0, `ring_full` low, `done_irq` low, every descriptor word 0;
  - ring start 0, ring end 3*DEPTH-1, ring size DEPTH, buffer size 2048;
  - threshold 1, timeout 0 (disabled), consumer index 0.
- R2: A written status word has the following fields:
  - frame length in bits 27:16;
  - bit 15 (owner) clear, bit 14 (end of packet) set, bit 13 (start of packet) set;
  - error flags in bits 4:0: bit 0 overrun, bit 1 CRC error, bit 2 receive error, bit 3 no buffer, bit 4 oversize;
  - every other bit zero.
- R3: An accepted frame writes its status word at word address start + 3*(producer & (size-1)). The write takes place at the clock edge where `frm_valid` is sampled high, and the word can be read on `rd_data` in the following cycle.
- R4: Bit 4 of the status word is also set when the frame length exceeds the programmed buffer size.
- R5: The producer index rises by one per written descriptor and wraps from 0xFFFF to 0.
- R6: `ring_full` is high when (producer - consumer) mod 2^16 equals the ring size. A frame arriving then is not written, the producer holds, and the drop count rises by one.
- R7: A frame whose status address would lie beyond the ring end register, or beyond the array, is dropped the same way.
- R8: A write to the consumer register (`cfg_addr`=5, bits 15:0) frees slots, so that frames are accepted again.
- R9: The block counts unreported descriptors. When a written descriptor makes that count reach the threshold (`cfg_addr`=3, bits 15:0; 0 acts as 1), `done_irq` is high for one cycle after that edge and the count clears.
- R10: The timeout (`cfg_addr`=4, bits 15:0) is counted in ticks of TICK_CYCLES clocks. Each written descriptor restarts the timer. If V is nonzero and descriptors are unreported, `done_irq` rises in the cycle after the edge V*TICK_CYCLES cycles after the last write, and the count clears. V=0 disables the timeout.
- R11: The address port writes descriptor words whose address mod 3 is 1 or 2. Writes aimed at a status word (address mod 3 = 0) leave it unchanged.
- R12: The size register (`cfg_addr`=2) holds the ring size in bits 31:16 and the buffer size in bytes in bits 15:0. Ring start is `cfg_addr`=0 and ring end is `cfg_addr`=1, both in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| frm_valid | input | 1 | Frame-complete strobe |
| frm_len | input | 12 | Received frame length in bytes |
| frm_err | input | 5 | Error flags for the frame |
| ad_we | input | 1 | Buffer address word write strobe |
| ad_addr | input | AW = clog2(3*DEPTH) | Descriptor word address for address writes |
| ad_data | input | 32 | Buffer address word data |
| rd_addr | input | AW | Descriptor word read address |
| rd_data | output | 32 | Descriptor word read data (combinational) |
| prod_idx | output | 16 | Producer index |
| ring_full | output | 1 | Ring holds size unconsumed descriptors |
| drop_cnt | output | 16 | Count of refused frames |
| done_irq | output | 1 | Coalesced done pulse |

## Verification
The hardest case to reach is the producer wrapping from 0xFFFF to 0 with the fullness test still correct across the wrap. That needs tens of thousands of accepted frames without the ring ever filling. The bench gets there by loading the consumer index with a value chosen so that the producer-consumer distance climbs through the 16-bit wrap and stops just below the ring size. It then holds the frame strobe high for one long back-to-back stream. One more frame after the wrap must land in slot 0 and leave the ring exactly full. The timeout is also checked to the exact cycle, including a restart by a second frame.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int IDX_W = 16;
    localparam int LEN_W = 12;
    localparam int ERR_W = 5;
    localparam int ERR_OVERSIZE = 4;

    typedef enum logic [2:0] {
        SEL_START  = 3'd0,
        SEL_END    = 3'd1,
        SEL_SIZE   = 3'd2,
        SEL_THRESH = 3'd3,
        SEL_TMO    = 3'd4,
        SEL_CONS   = 3'd5
    } cfg_sel_e;

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] last;
        logic [15:0] size;
        logic [15:0] buf_bytes;
        logic [15:0] thresh;
        logic [15:0] tmo;
        logic [15:0] cons;
    } ring_cfg_t;

    typedef struct packed {
        logic [3:0]       rsvd_hi;
        logic [LEN_W-1:0] len;
        logic             own;
        logic             eop;
        logic             sop;
        logic [7:0]       rsvd_lo;
        logic [ERR_W-1:0] err;
    } rx_status_t;

    function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                                input logic [ERR_W-1:0] err,
                                                input logic oversz);
        rx_status_t s;
        s       = '0;
        s.len   = len;
        s.own   = 1'b0;
        s.eop   = 1'b1;
        s.sop   = 1'b1;
        s.err   = err;
        s.err[ERR_OVERSIZE] = err[ERR_OVERSIZE] | oversz;
        return s;
    endfunction

    function automatic logic [1:0] word_phase(input logic [15:0] a);
        return 2'(a % 16'd3);
    endfunction

endpackage

// File: rtl/rxring_cfg.sv
module rxring_cfg
    import rxring_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output ring_cfg_t   cfg
);
    localparam logic [15:0] LAST_RST = 16'(3 * DEPTH - 1);
    localparam logic [15:0] SIZE_RST = 16'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.start     <= '0;
            cfg.last      <= LAST_RST;
            cfg.size      <= SIZE_RST;
            cfg.buf_bytes <= 16'd2048;
            cfg.thresh    <= 16'd1;
            cfg.tmo       <= '0;
            cfg.cons      <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_addr))
                SEL_START:  cfg.start  <= cfg_wdata[15:0];
                SEL_END:    cfg.last   <= cfg_wdata[15:0];
                SEL_SIZE: begin
                    cfg.size      <= cfg_wdata[31:16];
                    cfg.buf_bytes <= cfg_wdata[15:0];
                end
                SEL_THRESH: cfg.thresh <= cfg_wdata[15:0];
                SEL_TMO:    cfg.tmo    <= cfg_wdata[15:0];
                SEL_CONS:   cfg.cons   <= cfg_wdata[15:0];
                default: ;
            endcase
        end
    end

    assert_cons_load_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 3'd5) |=> cfg.cons == $past(cfg_wdata[15:0]));

    assert_size_load_R12: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 3'd2) |=> cfg.size == $past(cfg_wdata[31:16]));

endmodule

// File: rtl/rxring_desc_mem.sv
module rxring_desc_mem
    import rxring_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int WORDS = 3 * DEPTH,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_we,
    input  logic [AW-1:0] st_addr,
    input  logic [31:0]   st_data,
    input  logic          ad_we,
    input  logic [AW-1:0] ad_addr,
    input  logic [31:0]   ad_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);
    localparam logic [AW-1:0] WORDS_L = AW'(WORDS);

    logic [31:0] mem [WORDS];
    logic        ad_in_range;
    logic        ad_ok;
    logic        ad_clash;

    assign ad_in_range = ad_addr < WORDS_L;
    assign ad_clash    = st_we && (st_addr == ad_addr);
    assign ad_ok       = ad_we && ad_in_range && (word_phase(16'(ad_addr)) != 2'd0) && !ad_clash;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (st_we) mem[st_addr] <= st_data;
            if (ad_ok) mem[ad_addr] <= ad_data;
        end
    end

    assign rd_data = (rd_addr < WORDS_L) ? mem[rd_addr] : '0;

    logic [31:0] guard_word;
    assign guard_word = ad_in_range ? mem[ad_addr] : '0;

    assert_status_guard_R11: assert property (@(posedge clk) disable iff (rst)
        (ad_we && ad_in_range && word_phase(16'(ad_addr)) == 2'd0 && !ad_clash)
        |=> mem[$past(ad_addr)] == $past(guard_word));

endmodule

// File: rtl/rxring_coalesce.sv
module rxring_coalesce #(
    parameter  int TICK_CYCLES = 410,
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [15:0] thresh,
    input  logic [15:0] tmo,
    output logic        done
);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] pre;
    logic [15:0]   tcnt;
    logic [15:0]   pending;
    logic [15:0]   pend_nx;
    logic          tick;
    logic          thr_hit;
    logic          tmo_hit;

    assign tick    = (pre == PRE_LAST);
    assign pend_nx = pending + 16'd1;
    assign thr_hit = wr && (pend_nx >= thresh);
    assign tmo_hit = !wr && tick && (pending != '0) && (tmo != '0) &&
                     (16'(tcnt + 16'd1) == tmo);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre     <= '0;
            tcnt    <= '0;
            pending <= '0;
            done    <= 1'b0;
        end else begin
            done <= thr_hit || tmo_hit;
            if (wr) begin
                pre     <= '0;
                tcnt    <= '0;
                pending <= thr_hit ? '0 : pend_nx;
            end else begin
                pre <= tick ? '0 : pre + PW'(1);
                if (tick && tcnt != 16'hFFFF) tcnt <= tcnt + 16'd1;
                if (tmo_hit) pending <= '0;
            end
        end
    end

    assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr && pending == '0) |=> !done);

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        wr |=> (pre == '0 && tcnt == '0));

    assert_clear_on_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> pending == '0 || $past(wr));

endmodule

// File: rtl/rxring_wb.sv
module rxring_wb
    import rxring_pkg::*;
#(
    parameter  int DEPTH       = 32,
    parameter  int TICK_CYCLES = 410,
    localparam int WORDS       = 3 * DEPTH,
    localparam int AW          = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          frm_valid,
    input  logic [11:0]   frm_len,
    input  logic [4:0]    frm_err,
    input  logic          ad_we,
    input  logic [AW-1:0] ad_addr,
    input  logic [31:0]   ad_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic [15:0]   prod_idx,
    output logic          ring_full,
    output logic [15:0]   drop_cnt,
    output logic          done_irq
);
    ring_cfg_t   cfg;
    logic [15:0] slot;
    logic [17:0] waddr_full;
    logic        in_range;
    logic        accept;
    logic        refuse;
    logic        oversz;
    logic [31:0] st_data;
    logic [AW-1:0] st_addr;

    rxring_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    assign slot       = prod_idx & (cfg.size - 16'd1);
    assign waddr_full = {2'b00, cfg.start} + 18'(slot) * 18'd3;
    assign in_range   = (waddr_full <= {2'b00, cfg.last}) && (waddr_full < 18'(WORDS));
    assign ring_full  = (16'(prod_idx - cfg.cons) == cfg.size);
    assign accept     = frm_valid && !ring_full && in_range;
    assign refuse     = frm_valid && !accept;
    assign oversz     = {4'b0000, frm_len} > cfg.buf_bytes;
    assign st_data    = pack_status(frm_len, frm_err, oversz);
    assign st_addr    = AW'(waddr_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_idx <= '0;
            drop_cnt <= '0;
        end else begin
            if (accept) prod_idx <= prod_idx + 16'd1;
            if (refuse) drop_cnt <= drop_cnt + 16'd1;
        end
    end

    rxring_desc_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .st_we   (accept),
        .st_addr (st_addr),
        .st_data (st_data),
        .ad_we   (ad_we),
        .ad_addr (ad_addr),
        .ad_data (ad_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rxring_coalesce #(.TICK_CYCLES(TICK_CYCLES)) u_coal (
        .clk    (clk),
        .rst    (rst),
        .wr     (accept),
        .thresh (cfg.thresh),
        .tmo    (cfg.tmo),
        .done   (done_irq)
    );

    assert_prod_step_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prod_idx == $past(prod_idx)) || (prod_idx == 16'($past(prod_idx) + 16'd1)));

    assert_full_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && ring_full) |=> prod_idx == $past(prod_idx));

    assert_drop_count_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && ring_full) |=> drop_cnt == 16'($past(drop_cnt) + 16'd1));

    assert_done_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_irq) |-> $past(accept) || $past(prod_idx) == prod_idx);

endmodule

// File: tb/rxring_wb_test.sv
`timescale 1ns/1ps
module rxring_wb_test;
    localparam int DEPTH = 8;
    localparam int TICK  = 4;
    localparam int WORDS = 3 * DEPTH;
    localparam int AW    = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [2:0]    cfg_addr;
    logic [31:0]   cfg_wdata;
    logic          frm_valid;
    logic [11:0]   frm_len;
    logic [4:0]    frm_err;
    logic          ad_we;
    logic [AW-1:0] ad_addr;
    logic [31:0]   ad_data;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic [15:0]   prod_idx;
    logic          ring_full;
    logic [15:0]   drop_cnt;
    logic          done_irq;

    always #10 clk = ~clk;

    rxring_wb #(.DEPTH(DEPTH), .TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .frm_valid(frm_valid), .frm_len(frm_len), .frm_err(frm_err),
        .ad_we(ad_we), .ad_addr(ad_addr), .ad_data(ad_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .prod_idx(prod_idx),
        .ring_full(ring_full), .drop_cnt(drop_cnt), .done_irq(done_irq)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    int m_prod = 0, m_cons = 0, m_drop = 0, m_size = DEPTH, m_start = 0;
    int m_last = WORDS - 1, m_buf = 2048, m_thr = 1, m_pend = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    task automatic wcfg(input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cons(input int v);
        m_cons = v & 16'hFFFF;
        wcfg(5, 32'(m_cons));
    endtask

    task automatic wad(input int addr, input logic [31:0] data);
        @(negedge clk);
        ad_we = 1'b1; ad_addr = AW'(addr); ad_data = data;
        @(negedge clk);
        ad_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int addr, input logic [31:0] exp);
        rd_addr = AW'(addr);
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic send(input int len, input int err, input string req);
        int slot, addr;
        bit acc, edone;
        logic [31:0] exp_st;
        slot = m_prod & (m_size - 1);
        addr = m_start + 3 * slot;
        acc  = (((m_prod - m_cons) & 16'hFFFF) != m_size) && (addr <= m_last) && (addr < WORDS);
        exp_st = (32'(len) << 16) | 32'h6000 | 32'(err) | ((len > m_buf) ? 32'h10 : 32'h0);
        @(negedge clk);
        frm_valid = 1'b1; frm_len = 12'(len); frm_err = 5'(err);
        @(negedge clk);
        frm_valid = 1'b0;
        if (acc) begin
            edone  = (m_pend + 1 >= m_thr);
            m_pend = edone ? 0 : m_pend + 1;
            m_prod = (m_prod + 1) & 16'hFFFF;
        end else begin
            edone  = 1'b0;
            m_drop = (m_drop + 1) & 16'hFFFF;
        end
        chk({req, " R5 producer"}, 32'(prod_idx), 32'(m_prod));
        chk({req, " R6 drop count"}, 32'(drop_cnt), 32'(m_drop));
        chk({req, " R9 done"}, 32'(done_irq), 32'(edone));
        chk({req, " R6 full flag"}, 32'(ring_full), 32'(((m_prod - m_cons) & 16'hFFFF) == m_size));
        if (acc) rd_chk({req, " R2 status word"}, addr, exp_st);
    endtask

    initial begin
        #3_800_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frm_valid = 0; frm_len = 0;
        frm_err = 0; ad_we = 0; ad_addr = 0; ad_data = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 producer", 32'(prod_idx), 0);
        chk("R1 drop", 32'(drop_cnt), 0);
        chk("R1 full", 32'(ring_full), 0);
        chk("R1 done", 32'(done_irq), 0);
        rd_chk("R1 descriptor word", 0, 0);

        // R11 address words stored, status positions protected
        wad(1, 32'hA5A5_0001);
        wad(2, 32'h0000_0077);
        wad(0, 32'hDEAD_BEEF);
        wad(3, 32'h1234_5678);
        rd_chk("R11 address low", 1, 32'hA5A5_0001);
        rd_chk("R11 address high", 2, 32'h0000_0077);
        rd_chk("R11 status word untouched", 0, 0);
        rd_chk("R11 second status untouched", 3, 0);

        // R2 R3 sweep through a full ring with threshold 1
        for (int i = 0; i < DEPTH; i++)
            send(60 + 37 * i, (i < 5) ? (1 << i) : 0, "R3 sweep");
        chk("R6 full after size frames", 32'(ring_full), 1);
        send(99, 0, "R6 refused when full");
        rd_chk("R11 address kept after status write", 1, 32'hA5A5_0001);

        // R8 consumer returns slots
        set_cons(3);
        chk("R8 not full after consumer write", 32'(ring_full), 0);
        for (int i = 0; i < 4; i++) send(200 + i, 5'h0A, "R8 refill");

        // R4 R12 buffer size and oversize flag
        m_buf = 100;
        wcfg(2, {16'd8, 16'd100});
        set_cons(m_prod);
        send(101, 0, "R4 longer than buffer");
        send(100, 0, "R4 equal to buffer");
        send(100, 5'h10, "R4 flag from input");

        // R12 smaller ring size
        m_size = 4;
        wcfg(2, {16'd4, 16'd2048});
        m_buf = 2048;
        set_cons(m_prod);
        for (int i = 0; i < 5; i++) send(300 + i, 0, "R12 size four");
        m_size = 8;
        wcfg(2, {16'd8, 16'd2048});

        // R9 threshold coalescing
        set_cons(m_prod);
        m_thr = 3;
        wcfg(3, 32'd3);
        for (int i = 0; i < 7; i++) send(400 + i, 0, "R9 threshold three");
        m_thr = 0;
        wcfg(3, 32'd0);
        send(500, 0, "R9 threshold zero");
        m_thr = 1;
        wcfg(3, 32'd1);

        // R7 ring start and end bounds
        set_cons(m_prod);
        m_start = 12;
        wcfg(0, 32'd12);
        for (int i = 0; i < 6; i++) send(600 + i, 0, "R7 start bound");
        m_start = 0;
        wcfg(0, 32'd0);
        m_last = 14;
        wcfg(1, 32'd14);
        for (int i = 0; i < 4; i++) send(700 + i, 0, "R7 end bound");
        m_last = WORDS - 1;
        wcfg(1, 32'(WORDS - 1));

        // R10 timeout
        set_cons(m_prod);
        m_thr = 4;
        wcfg(3, 32'd4);
        wcfg(4, 32'd2);
        send(800, 0, "R10 timeout arm");
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R10 timeout fire cycle", 32'(done_irq), 32'(k == 2 * TICK));
        end
        m_pend = 0;
        send(801, 0, "R10 restart first");
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk("R10 no early fire", 32'(done_irq), 0);
        end
        send(802, 0, "R10 restart second");
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R10 restarted fire cycle", 32'(done_irq), 32'(k == 2 * TICK));
        end
        m_pend = 0;
        wcfg(4, 32'd0);
        send(803, 0, "R10 disabled");
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk("R10 disabled no fire", 32'(done_irq), 0);
        end
        m_thr = 1;
        wcfg(3, 32'd1);
        send(804, 0, "R9 pending released");

        // R5 producer wrap with a long back-to-back stream
        begin
            int n;
            n = 65536 - m_prod;
            set_cons(16'hFFF9);
            @(negedge clk);
            frm_valid = 1'b1; frm_len = 12'd64; frm_err = 5'd0;
            repeat (n) @(negedge clk);
            frm_valid = 1'b0;
            m_prod = 0;
            m_pend = 0;
            chk("R5 producer wrapped", 32'(prod_idx), 0);
            chk("R5 no drops in stream", 32'(drop_cnt), 32'(m_drop));
            send(77, 5'h03, "R5 after wrap");
            chk("R6 full across wrap", 32'(ring_full), 1);
            send(78, 0, "R6 refused across wrap");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule